// File: doc/BRIEF.md
# USB Host Line Event Interrupt Register

This block collects host-side bus events into one sticky status byte. Three timed detectors watch the single-ended line levels `dp_i`/`dm_i`. Each one counts clock cycles against a limit derived from a cycles-per-microsecond input. One reports a quiet, non-SE0 bus after a device plugs in. One reports a held K state, which signals a remote resume. One reports a bus that has sat in J for several milliseconds. Strobes from the neighbouring token engine set their flags directly: stall handshake, token complete, start-of-frame threshold, masked error and detach.

Software reads the byte through a one-cycle read strobe on a 16-bit data path. It acknowledges events by writing ones to the bits to be cleared. A single level interrupt is the OR of the flags that pass an enable mask. After a detach is reported, the detach flag cannot be set again until the bus reset state has been released.

Top module: `usb_line_irq`

## Requirements
- R1: While `rst_ni` is low, all eight flags are 0, `rdata_o` is 0 and `irq_o` is 0.
- R2: One cycle after `rd_i` is high, `rdata_o[7:0]` holds the flags as they were in the strobe cycle and `rdata_o[15:8]` is 0. Bit 7 is stall, bit 6 attach, bit 5 resume, bit 4 idle, bit 3 token done, bit 2 start-of-frame, bit 1 error and bit 0 detach.
- R3: A flag stays set until a cycle with `wr_i` high and a 1 in its `wdata_i` bit position. Writing 0 to a bit leaves it unchanged, and `wdata_i[15:8]` has no effect.
- R4: If a set event and a write-one clear reach the same bit in the same cycle, the bit ends up set.
- R5: A one-cycle pulse on `stall_evt_i`, `token_done_i` or `sof_evt_i` sets bit 7, 3 or 2 respectively, visible on the next cycle.
- R6: Bit 1 sets only in a cycle where `err_evt_i & err_en_i` is non-zero.
- R7: Bit 6 sets once the line has been non-SE0 (`dp_i` or `dm_i` high) and unchanged for floor(`cyc_per_us_i`*5/2) cycles, which is 2.5 µs. Any change of line level or any SE0 restarts the count.
- R8: Bit 5 sets once the line has been in K for floor(`cyc_per_us_i`*5/2) cycles without a break. With `low_speed_i`=1, K is `dp_i`=1,`dm_i`=0. With `low_speed_i`=0, K is `dp_i`=0,`dm_i`=1.
- R9: Bit 4 sets once the line has been in J (the opposite of K) for `cyc_per_us_i`*3000 cycles without a break, which is 3 ms.
- R10: Each timed detector fires at most once per uninterrupted episode of its condition. Breaking the condition restarts the count and re-arms the detector.
- R11: After `detach_evt_i` sets bit 0, further detach pulses are ignored until `bus_reset_i` falls from 1 to 0.
- R12: `irq_o` is high exactly when some flag is set whose bit in `irq_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | D+ line level |
| dm_i | input | 1 | D- line level |
| low_speed_i | input | 1 | 1 selects low-speed line polarity |
| cyc_per_us_i | input | 8 | Clock cycles per microsecond |
| stall_evt_i | input | 1 | Stall handshake strobe |
| token_done_i | input | 1 | Token processing complete strobe |
| sof_evt_i | input | 1 | Start-of-frame threshold strobe |
| err_evt_i | input | 8 | Error condition strobes |
| err_en_i | input | 8 | Error enable mask |
| detach_evt_i | input | 1 | Detach detected strobe |
| bus_reset_i | input | 1 | Bus reset state active |
| irq_en_i | input | 8 | Interrupt enable per flag |
| wr_i | input | 1 | Write strobe (write-one clear) |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid one cycle after `rd_i` |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check several rules on every cycle. They cover flag stickiness, clear-by-one, set priority over clear, the read data path, the error mask, and the single detach report per reset release. They also check that a resume, idle or attach flag only rises after the matching line state. The timed thresholds, the restart after a broken episode and the polarity swap between speeds are only shown by the bench's directed line scenarios. Those scenarios check flags inside windows around the expected cycle counts. Random strobe and write traffic is compared cycle by cycle against a bench model of the register.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int FLAG_W   = 8;
  localparam int B_STALL  = 7;
  localparam int B_ATTACH = 6;
  localparam int B_RESUME = 5;
  localparam int B_IDLE   = 4;
  localparam int B_TOKEN  = 3;
  localparam int B_SOF    = 2;
  localparam int B_ERROR  = 1;
  localparam int B_DETACH = 0;

  localparam int N_TMR   = 3;
  localparam int T_ATT   = 0;
  localparam int T_RES   = 1;
  localparam int T_IDLE  = 2;

  function automatic logic is_se0(logic dp, logic dm);
    return !dp && !dm;
  endfunction

  // K: differential 1 at low speed, differential 0 at full speed
  function automatic logic is_k(logic dp, logic dm, logic ls);
    return ls ? (dp && !dm) : (!dp && dm);
  endfunction

  function automatic logic is_j(logic dp, logic dm, logic ls);
    return ls ? (!dp && dm) : (dp && !dm);
  endfunction
endpackage

// File: rtl/usb_line_timer.sv
module usb_line_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cond_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             done_q;

  assign last   = (limit_i == '0) ? '0 : limit_i - 1'b1;
  assign fire_o = cond_i && !done_q && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!cond_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cnt_q < last) cnt_q <= cnt_q + 1'b1;
      if (fire_o) done_q <= 1'b1;
    end
  end

  // R10: a broken condition re-arms the detector
  p_rearm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cond_i) |=> (cnt_q == '0 && !done_q));
endmodule

// File: rtl/usb_detach_gate.sv
module usb_detach_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic bus_reset_i,
  output logic set_o
);
  logic armed_q;
  logic rst_q;

  assign set_o = evt_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      rst_q   <= 1'b0;
    end else begin
      rst_q <= bus_reset_i;
      if (set_o)                       armed_q <= 1'b0;
      else if (rst_q && !bus_reset_i)  armed_q <= 1'b1;
    end
  end

  p_one_detach_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |=> !set_o);
endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= 1'b0;
      else if (set_i[b])  q <= 1'b1;   // set beats clear
      else if (clr_i[b])  q <= 1'b0;
    end
    assign flags_o[b] = q;

    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> flags_o[b]);
    p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[b] && !set_i[b]) |=> !flags_o[b]);
    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[b] && !clr_i[b]) |=> flags_o[b]);
  end
endmodule

// File: rtl/usb_line_irq.sv
module usb_line_irq
  import usb_irq_pkg::*;
#(
  parameter int US_W          = 8,
  parameter int CNT_W         = 24,
  parameter int ATT_HALF_US   = 5,
  parameter int IDLE_US       = 3000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dp_i,
  input  logic        dm_i,
  input  logic        low_speed_i,
  input  logic [7:0]  cyc_per_us_i,
  input  logic        stall_evt_i,
  input  logic        token_done_i,
  input  logic        sof_evt_i,
  input  logic [7:0]  err_evt_i,
  input  logic [7:0]  err_en_i,
  input  logic        detach_evt_i,
  input  logic        bus_reset_i,
  input  logic [7:0]  irq_en_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        irq_o
);
  localparam int DW = 16;

  logic [CNT_W-1:0]  cyc_ext;
  logic [CNT_W-1:0]  lim_att;
  logic [CNT_W-1:0]  lim_idle;
  logic [1:0]        line_q;
  logic              se0_now, k_now, j_now;
  logic [N_TMR-1:0]  t_cond;
  logic [N_TMR-1:0]  t_fire;
  logic [CNT_W-1:0]  t_lim [N_TMR];
  logic              det_set;
  logic [FLAG_W-1:0] set_v, clr_v, flags;
  logic [DW-1:0]     rdata_q;
  logic              unused_hi;

  assign cyc_ext  = CNT_W'(cyc_per_us_i);
  assign lim_att  = (cyc_ext * CNT_W'(ATT_HALF_US)) >> 1;
  assign lim_idle = cyc_ext * CNT_W'(IDLE_US);

  assign se0_now = is_se0(dp_i, dm_i);
  assign k_now   = is_k(dp_i, dm_i, low_speed_i);
  assign j_now   = is_j(dp_i, dm_i, low_speed_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 2'b00;
    else         line_q <= {dp_i, dm_i};
  end

  // attach: non-SE0 and no line change
  assign t_cond[T_ATT]  = !se0_now && ({dp_i, dm_i} == line_q);
  assign t_cond[T_RES]  = k_now;
  assign t_cond[T_IDLE] = j_now;
  assign t_lim[T_ATT]   = lim_att;
  assign t_lim[T_RES]   = lim_att;
  assign t_lim[T_IDLE]  = lim_idle;

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    usb_line_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cond_i  (t_cond[t]),
      .limit_i (t_lim[t]),
      .fire_o  (t_fire[t])
    );
  end

  usb_detach_gate u_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (detach_evt_i),
    .bus_reset_i (bus_reset_i),
    .set_o       (det_set)
  );

  always_comb begin
    set_v           = '0;
    set_v[B_STALL]  = stall_evt_i;
    set_v[B_ATTACH] = t_fire[T_ATT];
    set_v[B_RESUME] = t_fire[T_RES];
    set_v[B_IDLE]   = t_fire[T_IDLE];
    set_v[B_TOKEN]  = token_done_i;
    set_v[B_SOF]    = sof_evt_i;
    set_v[B_ERROR]  = |(err_evt_i & err_en_i);
    set_v[B_DETACH] = det_set;
  end

  assign clr_v     = wr_i ? wdata_i[FLAG_W-1:0] : '0;
  assign unused_hi = ^wdata_i[DW-1:FLAG_W];

  usb_irq_flags #(.W(FLAG_W)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .flags_o (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= {{(DW-FLAG_W){1'b0}}, flags};
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(flags & irq_en_i);

  p_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (rdata_o[15:8] == 8'h00 && rdata_o[7:0] == $past(flags)));
  p_err_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags[B_ERROR] && (err_evt_i & err_en_i) == 8'h00) |=> !flags[B_ERROR]);
  p_attach_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[B_ATTACH]) |-> !$past(se0_now));
  p_resume_k_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[B_RESUME]) |-> $past(k_now));
  p_idle_j_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[B_IDLE]) |-> $past(j_now));
  p_irq_src_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags != '0));
endmodule

// File: tb/usb_line_irq_test.sv
`timescale 1ns/1ps
module usb_line_irq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dp_i = 0, dm_i = 0, low_speed_i = 0;
  logic [7:0]  cyc_per_us_i = 8'd4;
  logic        stall_evt_i = 0, token_done_i = 0, sof_evt_i = 0;
  logic [7:0]  err_evt_i = 0, err_en_i = 0;
  logic        detach_evt_i = 0, bus_reset_i = 0;
  logic [7:0]  irq_en_i = 0;
  logic        wr_i = 0, rd_i = 0;
  logic [15:0] wdata_i = 0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;

  usb_line_irq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .dp_i(dp_i), .dm_i(dm_i),
    .low_speed_i(low_speed_i), .cyc_per_us_i(cyc_per_us_i),
    .stall_evt_i(stall_evt_i), .token_done_i(token_done_i),
    .sof_evt_i(sof_evt_i), .err_evt_i(err_evt_i), .err_en_i(err_en_i),
    .detach_evt_i(detach_evt_i), .bus_reset_i(bus_reset_i),
    .irq_en_i(irq_en_i), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic rd_reg(output logic [15:0] v);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic wr_reg(input logic [15:0] d);
    wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic line(input logic dp, input logic dm);
    dp_i = dp; dm_i = dm;
  endtask

  function automatic logic [7:0] next_flags(input logic [7:0] f, input logic [7:0] set, input logic [7:0] clr);
    return (f & ~clr) | set;
  endfunction

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  exp_f, prev_f, set_m, clr_m;
    logic        armed_m, brq_m, det_ok;
    int unsigned seed;
    seed = $urandom(32'd2024);

    // R1 reset state
    irq_en_i = 8'hFF;
    tick(3);
    check("R1 rdata in reset", rdata_o, 16'h0000);
    check("R1 irq in reset", {15'd0, irq_o}, 16'h0000);
    rst_ni = 1'b1;
    tick(1);
    rd_reg(v);
    check("R1 flags after reset", v, 16'h0000);

    // random strobes and writes against a model, line held at SE0
    exp_f = 8'h00; armed_m = 1'b1; brq_m = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      stall_evt_i  = ($urandom % 8) == 0;
      token_done_i = ($urandom % 8) == 0;
      sof_evt_i    = ($urandom % 8) == 0;
      err_evt_i    = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      err_en_i     = 8'($urandom);
      detach_evt_i = ($urandom % 8) == 0;
      bus_reset_i  = ($urandom % 6) == 0;
      wr_i         = ($urandom % 3) == 0;
      wdata_i      = 16'($urandom);
      rd_i         = 1'b1;
      irq_en_i     = 8'($urandom);
      @(posedge clk_i);
      det_ok = detach_evt_i && armed_m;
      set_m = {stall_evt_i, 3'b000, token_done_i, sof_evt_i,
               |(err_evt_i & err_en_i), det_ok};
      clr_m = wr_i ? wdata_i[7:0] : 8'h00;
      if (det_ok) armed_m = 1'b0;
      else if (brq_m && !bus_reset_i) armed_m = 1'b1;
      brq_m = bus_reset_i;
      prev_f = exp_f;
      exp_f = next_flags(exp_f, set_m, clr_m);
      @(negedge clk_i);
      check("R2/R3/R4/R5/R6/R11 random read", rdata_o, {8'h00, prev_f});
      check("R12 random irq", {15'd0, irq_o}, {15'd0, |(exp_f & irq_en_i)});
    end
    stall_evt_i = 0; token_done_i = 0; sof_evt_i = 0; err_evt_i = 0;
    detach_evt_i = 0; wr_i = 0; rd_i = 0; wdata_i = 0;
    bus_reset_i = 1'b1; tick(2); bus_reset_i = 1'b0; tick(2);
    wr_reg(16'h00FF);

    // R5 strobes
    token_done_i = 1; tick(1); token_done_i = 0;
    rd_reg(v); check("R5 token done bit3", {15'd0, v[3]}, 16'd1);
    // R3 upper write bits and zero bits ignored
    sof_evt_i = 1; tick(1); sof_evt_i = 0;
    wr_reg(16'hFF00);
    rd_reg(v); check("R3 upper write ignored", {8'h00, v[7:0]}, 16'h000C);
    check("R2 upper read zero", {8'h00, v[15:8]}, 16'h0000);
    wr_reg(16'h0008);
    rd_reg(v); check("R3 clear only bit3", v, 16'h0004);
    // R4 set beats clear
    stall_evt_i = 1; wr_i = 1; wdata_i = 16'h0080; tick(1);
    stall_evt_i = 0; wr_i = 0; wdata_i = 0;
    rd_reg(v); check("R4 set wins", {15'd0, v[7]}, 16'd1);
    wr_reg(16'h0080);
    rd_reg(v); check("R3 stall cleared", {15'd0, v[7]}, 16'd0);
    // R6 error mask
    err_en_i = 8'h0F; err_evt_i = 8'hF0; tick(1); err_evt_i = 0;
    rd_reg(v); check("R6 masked error", {15'd0, v[1]}, 16'd0);
    err_evt_i = 8'h04; tick(1); err_evt_i = 0;
    rd_reg(v); check("R6 enabled error", {15'd0, v[1]}, 16'd1);
    // R12 enable mask
    wr_reg(16'h00FF);
    stall_evt_i = 1; tick(1); stall_evt_i = 0;
    irq_en_i = 8'h7F; tick(1);
    check("R12 irq masked", {15'd0, irq_o}, 16'd0);
    irq_en_i = 8'h80; tick(1);
    check("R12 irq enabled", {15'd0, irq_o}, 16'd1);
    irq_en_i = 8'h00;
    // R11 detach gating
    wr_reg(16'h00FF);
    detach_evt_i = 1; tick(1); detach_evt_i = 0;
    rd_reg(v); check("R11 first detach", {15'd0, v[0]}, 16'd1);
    wr_reg(16'h0001);
    detach_evt_i = 1; tick(1); detach_evt_i = 0;
    rd_reg(v); check("R11 detach blocked", {15'd0, v[0]}, 16'd0);
    bus_reset_i = 1; tick(3);
    detach_evt_i = 1; tick(1); detach_evt_i = 0;
    rd_reg(v); check("R11 blocked during reset", {15'd0, v[0]}, 16'd0);
    bus_reset_i = 0; tick(1);
    detach_evt_i = 1; tick(1); detach_evt_i = 0;
    rd_reg(v); check("R11 rearmed after reset release", {15'd0, v[0]}, 16'd1);

    // timed detectors, cyc_per_us=4 -> 2.5us = 10 cycles, 3ms = 12000
    low_speed_i = 1; line(0, 0); tick(2); wr_reg(16'h00FF);
    line(1, 0); tick(5);
    rd_reg(v); check("R8 resume early", {15'd0, v[5]}, 16'd0);
    tick(10);
    rd_reg(v); check("R8 resume low speed K", {15'd0, v[5]}, 16'd1);
    wr_reg(16'h00FF); tick(30);
    rd_reg(v); check("R10 no refire resume", {15'd0, v[5]}, 16'd0);
    check("R10 no refire attach", {15'd0, v[6]}, 16'd0);
    line(0, 0); tick(2); line(1, 0); tick(6); line(0, 0); tick(2); line(1, 0); tick(6);
    rd_reg(v); check("R10 restart after break", {15'd0, v[5]}, 16'd0);
    tick(8);
    rd_reg(v); check("R10 fires after full run", {15'd0, v[5]}, 16'd1);

    low_speed_i = 0; line(0, 0); tick(2); wr_reg(16'h00FF);
    line(1, 0); tick(20);
    rd_reg(v); check("R8 full speed J is not K", {15'd0, v[5]}, 16'd0);
    line(0, 1); tick(15);
    rd_reg(v); check("R8 full speed K", {15'd0, v[5]}, 16'd1);

    line(0, 0); tick(2); wr_reg(16'h00FF);
    line(1, 0); tick(11000);
    rd_reg(v); check("R9 idle early", {15'd0, v[4]}, 16'd0);
    tick(1500);
    rd_reg(v); check("R9 idle after 3 ms", {15'd0, v[4]}, 16'd1);

    line(0, 0); tick(2); wr_reg(16'h00FF);
    for (int k = 0; k < 8; k++) begin
      line(1, 0); tick(5);
      line(0, 1); tick(5);
    end
    rd_reg(v); check("R7 activity blocks attach", {15'd0, v[6]}, 16'd0);
    line(0, 0); tick(40);
    rd_reg(v); check("R7 SE0 blocks attach", {15'd0, v[6]}, 16'd0);
    line(1, 0); tick(15);
    rd_reg(v); check("R7 attach after quiet bus", {15'd0, v[6]}, 16'd1);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule